// File: doc/BRIEF.md
# Clocked Serial Frame Receiver with Overrun Lock

This block is the receive side of a synchronous serial port. It collects 8-bit frames from a serial data line, one bit per rising edge of a transfer clock, least significant bit first. In master mode it makes the transfer clock itself by dividing the system clock. In slave mode it takes the transfer clock from an external pin, passes it through a synchroniser and finds its rising edges in the system clock domain.

A completed frame goes into a data register and raises a full flag. Software reads the data register through a read strobe, and that read clears the flag. If the full flag has not been cleared by the time the eighth bit of the next frame arrives, that frame is dropped and an overrun flag is set. The overrun flag stops all reception and stops the master clock. Reception stays stopped until software clears the flag with a clear strobe. A receive interrupt request follows the full flag when the interrupt enable is set. An error interrupt request follows the overrun flag.

Top module: `srx_unit`

## Requirements
- R1: After reset, rx_data is 0, and rx_full, ovr_flag, rx_irq, err_irq and sclk_out are all 0.
- R2: While rx_en is 0, transfer clock edges are ignored and no frame completes. Clearing rx_en throws away a partly received frame, so the next frame starts again at bit 0.
- R3: In slave mode (master_mode=0), sclk_in and sdata_in each pass through a two-flop synchroniser. Each rising edge of the synchronised clock samples one data bit. The first bit received is rx_data bit 0 and the eighth is bit 7.
- R4: In master mode (master_mode=1), sclk_out toggles every HALF_DIV system clocks, which gives a period of 2*HALF_DIV, but only while rx_en is 1 and ovr_flag is 0. Otherwise sclk_out is held at 0. sdata_in is sampled on each rising edge of sclk_out.
- R5: When the eighth bit of a frame arrives and the full flag is clear, the frame is loaded into rx_data and rx_full becomes 1.
- R6: rx_irq equals rx_full AND int_en. err_irq equals ovr_flag.
- R7: A one-cycle pulse on rd_strobe clears rx_full. If the pulse falls in the same cycle as the eighth bit, the read counts first: the new frame is loaded, rx_full stays 1 and no overrun is flagged.
- R8: If rx_full is 1 when the eighth bit arrives and no read happens in that cycle, ovr_flag becomes 1. rx_data keeps the earlier frame and rx_full stays 1.
- R9: While ovr_flag is 1, no frame is received, even after rx_full is read clear. A pulse on clr_ovr clears ovr_flag. The next frame is then received from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = generate the transfer clock, 0 = use sclk_in |
| rx_en | input | 1 | Receive enable |
| int_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | One-cycle read of the data register; clears rx_full |
| clr_ovr | input | 1 | One-cycle write that clears the overrun flag |
| sclk_in | input | 1 | External transfer clock (slave mode) |
| sdata_in | input | 1 | Serial receive data |
| sclk_out | output | 1 | Generated transfer clock (master mode) |
| rx_data | output | 8 | Last frame accepted |
| rx_full | output | 1 | Receive data full flag |
| ovr_flag | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bench targets a read that lands in exactly the same cycle as the eighth bit. A design that judged overrun before counting the read would drop a frame that software had in fact made room for. It sends frames while the overrun lock is active, both before and after the full flag is read. A design that only blocked loading, and did not freeze reception, would pick up a stray frame or resume in the middle of a frame. It clears rx_en partway through a frame to catch a bit counter that is not flushed. In master mode it times the generated clock and checks that the clock stays low while the block is disabled or locked by an overrun.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int unsigned FRAME_W = 8;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [CNT_W-1:0]   bitcnt_t;

  typedef enum logic [1:0] {
    OUT_NONE    = 2'd0,
    OUT_LOAD    = 2'd1,
    OUT_OVERRUN = 2'd2
  } outcome_e;

  // LSB-first shift: a new bit enters at the top and moves down.
  function automatic frame_t shift_in(input frame_t cur, input logic bit_in);
    return {bit_in, cur[FRAME_W-1:1]};
  endfunction

  function automatic logic is_last_bit(input bitcnt_t cnt);
    return cnt == bitcnt_t'(FRAME_W - 1);
  endfunction

  // Result of a frame boundary. busy means the full flag is still set
  // once any read in the same cycle has been taken into account.
  function automatic outcome_e judge_frame(input logic done, input logic busy);
    if (!done)     return OUT_NONE;
    else if (busy) return OUT_OVERRUN;
    else           return OUT_LOAD;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise
);

  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;
  logic          sclk_q;
  logic          wrap;

  assign wrap = run && (div_q == LAST);
  assign rise = wrap && !sclk_q;
  assign sclk = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      div_q  <= '0;
      sclk_q <= !sclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  // R4: the level holds for the whole half period.
  p_half_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && (div_q != '0) |-> $stable(sclk_q));

  // R4: the clock is held low while stopped.
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk_q);

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
  import srx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flush,
  input  logic   edge_ok,
  input  logic   bit_in,
  output frame_t word,
  output logic   done
);

  bitcnt_t cnt_q;
  frame_t  sh_q;

  assign word = shift_in(sh_q, bit_in);
  assign done = edge_ok && is_last_bit(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (flush) begin
      cnt_q <= '0;
    end else if (edge_ok) begin
      sh_q  <= word;
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end

  // R3: a finished frame restarts the count at bit 0.
  p_restart_after_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt_q == '0));

  // R2: a flush discards any partial frame.
  p_flush_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));

endmodule

// File: rtl/srx_unit.sv
module srx_unit
  import srx_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         master_mode,
  input  logic         rx_en,
  input  logic         int_en,
  input  logic         rd_strobe,
  input  logic         clr_ovr,
  input  logic         sclk_in,
  input  logic         sdata_in,
  output logic         sclk_out,
  output logic [7:0]   rx_data,
  output logic         rx_full,
  output logic         ovr_flag,
  output logic         rx_irq,
  output logic         err_irq
);

  // Named internal events
  logic     rx_live;
  logic     gen_run;
  logic     m_rise;
  logic     s_clk, s_dat, s_prev, s_rise;
  logic     edge_src, edge_ok, bit_sel;
  logic     frame_done;
  frame_t   frame_word;
  outcome_e outcome;
  frame_t   data_q;
  logic     full_q, ovr_q;

  assign rx_live = rx_en && !ovr_q;
  assign gen_run = master_mode && rx_live;

  srx_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (gen_run),
    .sclk  (sclk_out),
    .rise  (m_rise)
  );

  logic [1:0] sync_d, sync_q;
  assign sync_d = {sdata_in, sclk_in};

  srx_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sync_d),
    .q     (sync_q)
  );

  assign s_clk = sync_q[0];
  assign s_dat = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_prev <= 1'b0;
    else        s_prev <= s_clk;
  end

  assign s_rise   = s_clk && !s_prev;
  assign edge_src = master_mode ? m_rise : s_rise;
  assign bit_sel  = master_mode ? sdata_in : s_dat;
  assign edge_ok  = edge_src && rx_live;

  srx_shifter u_shifter (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (!rx_live),
    .edge_ok (edge_ok),
    .bit_in  (bit_sel),
    .word    (frame_word),
    .done    (frame_done)
  );

  assign outcome = judge_frame(frame_done, full_q && !rd_strobe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (outcome == OUT_LOAD) begin
        data_q <= frame_word;
        full_q <= 1'b1;
      end else if (rd_strobe) begin
        full_q <= 1'b0;
      end
      if (outcome == OUT_OVERRUN) ovr_q <= 1'b1;
      else if (clr_ovr)           ovr_q <= 1'b0;
    end
  end

  assign rx_data  = data_q;
  assign rx_full  = full_q;
  assign ovr_flag = ovr_q;
  assign rx_irq   = full_q && int_en;
  assign err_irq  = ovr_q;

  // R5: the full flag only rises at the end of a frame.
  p_full_from_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(frame_done));

  // R7: a read with no frame ending clears the flag.
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !frame_done |=> !rx_full);

  // R8: overrun needs a pending frame at a frame boundary.
  p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(rx_full) && $past(frame_done));

  // R8: the stored frame is kept once overrun is flagged.
  p_data_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> $stable(rx_data));

  // R9: no frame completes during the overrun lock.
  p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> !frame_done);

  // R2: disabled reception completes nothing.
  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !frame_done);

  // R4: generated clock low in slave mode, when disabled, or during overrun.
  p_sclk_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(master_mode && rx_en && !ovr_flag) |=> !sclk_out);

endmodule

// File: tb/srx_unit_tb.sv
module srx_unit_tb;

  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b0, rx_en = 1'b0, int_en = 1'b0;
  logic rd_strobe = 1'b0, clr_ovr = 1'b0, sclk_in = 1'b0, sdata_in = 1'b0;
  logic sclk_out, rx_full, ovr_flag, rx_irq, err_irq;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic seq [8];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  srx_unit #(.HALF_DIV(HALF), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .rx_en(rx_en),
    .int_en(int_en), .rd_strobe(rd_strobe), .clr_ovr(clr_ovr),
    .sclk_in(sclk_in), .sdata_in(sdata_in), .sclk_out(sclk_out),
    .rx_data(rx_data), .rx_full(rx_full), .ovr_flag(ovr_flag),
    .rx_irq(rx_irq), .err_irq(err_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Rebuild the word from the order in which bits were sent (first = LSB).
  function automatic logic [7:0] rebuild();
    logic [7:0] r = '0;
    for (int i = 7; i >= 0; i--) r = {r[6:0], seq[i]};
    return r;
  endfunction

  function automatic logic irq_model(input logic full, input logic en);
    return full & en;
  endfunction

  task automatic s_bit(input logic b);
    sdata_in = b; sclk_in = 1'b0;
    repeat (4) @(negedge clk);
    sclk_in = 1'b1;
    repeat (4) @(negedge clk);
    sclk_in = 1'b0;
  endtask

  task automatic s_frame(input logic [7:0] w);
    for (int i = 0; i < 8; i++) begin seq[i] = w[i]; s_bit(w[i]); end
  endtask

  task automatic do_read();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr_ovr = 1'b1;
    @(negedge clk); clr_ovr = 1'b0;
  endtask

  task automatic m_frame(input logic [7:0] w, input logic check_period);
    int last = -1;
    @(negedge clk);
    rx_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      seq[i] = w[i];
      sdata_in = w[i];
      @(posedge sclk_out); #1;
      if (check_period && last >= 0) chk("R4 period", cyc - last, 2 * HALF);
      last = cyc;
    end
    repeat (2) @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] w, kept;
    int hi;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 data", rx_data, 0);
    chk("R1 full", rx_full, 0);
    chk("R1 ovr", ovr_flag, 0);
    chk("R1 irq", {rx_irq, err_irq, sclk_out}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 disabled: a full frame is ignored
    s_frame(8'hA5);
    repeat (4) @(negedge clk);
    chk("R2 disabled full", rx_full, 0);
    chk("R2 disabled data", rx_data, 0);

    // R3/R5/R6 random frames in slave mode
    rx_en = 1'b1;
    for (int k = 0; k < 8; k++) begin
      w = 8'($urandom);
      int_en = 1'($urandom);
      s_frame(w);
      chk("R3 data", rx_data, rebuild());
      chk("R5 full", rx_full, 1);
      chk("R6 rx_irq", rx_irq, irq_model(1'b1, int_en));
      do_read();
      chk("R7 read clears", rx_full, 0);
      chk("R6 rx_irq low", rx_irq, 0);
    end
    int_en = 1'b1;

    // R2 partial frame discarded when rx_en drops
    for (int i = 0; i < 3; i++) s_bit(1'b1);
    @(negedge clk); rx_en = 1'b0;
    repeat (3) @(negedge clk); rx_en = 1'b1;
    s_frame(8'h3C);
    chk("R2 partial flushed", rx_data, 8'h3C);
    do_read();

    // R8 overrun
    s_frame(8'h81);
    kept = rebuild();
    s_frame(8'h7E);
    chk("R8 ovr", ovr_flag, 1);
    chk("R6 err_irq", err_irq, 1);
    chk("R8 data kept", rx_data, kept);
    chk("R8 full stays", rx_full, 1);
    // R9 locked
    s_frame(8'h55);
    chk("R9 locked data", rx_data, kept);
    do_read();
    s_frame(8'hC3);
    chk("R9 locked after read", rx_full, 0);
    chk("R9 still ovr", ovr_flag, 1);
    do_clr();
    chk("R9 clr", {ovr_flag, err_irq}, 0);
    s_frame(8'h96);
    chk("R9 resumed", rx_data, 8'h96);
    chk("R9 resumed full", rx_full, 1);

    // R7 read in the same cycle as the eighth bit
    w = 8'h5A;
    for (int i = 0; i < 7; i++) s_bit(w[i]);
    sdata_in = w[7]; sclk_in = 1'b0;
    repeat (4) @(negedge clk);
    sclk_in = 1'b1;
    @(negedge clk); @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    sclk_in = 1'b0;
    chk("R7 same-cycle data", rx_data, 8'h5A);
    chk("R7 same-cycle full", rx_full, 1);
    chk("R7 same-cycle no ovr", ovr_flag, 0);
    do_read();
    rx_en = 1'b0;

    // R4 master mode
    master_mode = 1'b1;
    hi = 0;
    repeat (20) begin @(negedge clk); if (sclk_out) hi++; end
    chk("R4 idle low", hi, 0);
    m_frame(8'hE1, 1'b1);
    chk("R4 master data", rx_data, rebuild());
    chk("R5 master full", rx_full, 1);
    kept = rx_data;
    m_frame(8'h1F, 1'b0);
    chk("R8 master ovr", ovr_flag, 1);
    chk("R8 master kept", rx_data, kept);
    @(negedge clk); rx_en = 1'b1;
    hi = 0;
    repeat (30) begin @(negedge clk); if (sclk_out) hi++; end
    chk("R9 master clock stopped", hi, 0);
    rx_en = 1'b0;
    do_clr();
    do_read();
    w = 8'($urandom);
    m_frame(w, 1'b1);
    chk("R9 master resumed", rx_data, rebuild());
    report();
  end

endmodule